// File: doc/BRIEF.md
# DMA Address Generator with Buffer Wrapping

This block produces the running address for one side (read or write) of a DMA channel. Software loads two shadow registers at any time: a start address and a wrap base address. When the sequencer signals the start of a transfer, both shadows are copied into an active address and an active base. From then on the active address moves by a signed per-word step after every word. After every burst it moves either by a signed per-burst step or by a wrap reload.

A burst counter is loaded from the wrap-size setting at transfer start and counts down once per burst. The burst that finds the counter at zero triggers a wrap. The wrap adds a signed wrap step to the active base, loads the new base into the active address, and reloads the counter. A single transfer can therefore walk across several equally spaced buffers. Because the active pair is separate from the shadow pair, software can prepare the next transfer during the current one, as in ping-pong buffering. The sequencer that issues the strobes and the register bus that writes the shadows are outside this block.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the active address, the active base, the burst counter and both shadow registers are cleared to zero. A transfer started after reset without new shadow writes therefore shows `cur_addr` = 0.
- R2: A clock edge with `xfer_start` high copies the shadow start address into `cur_addr` and the shadow base into the active base. The copied base is seen at the next wrap.
- R3: An edge with `word_done` high, `burst_done` low and `xfer_start` low adds `word_step`, sign-extended from 16 to 32 bits, to `cur_addr`.
- R4: An edge with `burst_done` high and the burst counter not zero adds `burst_step`, sign-extended, to `cur_addr`, and decrements the counter by one.
- R5: When `word_done` and `burst_done` are both high on a non-wrapping edge, the new address is old address + sext(`word_step`) + sext(`burst_step`).
- R6: At transfer start the burst counter loads `wrap_size`. An edge with `burst_done` high and the counter at zero performs a wrap: active base becomes base + sext(`wrap_step`), `cur_addr` becomes that new base, and neither `word_step` nor `burst_step` is applied on that edge.
- R7: A wrap reloads the burst counter from `wrap_size`. With `wrap_size` = N, a wrap therefore occurs on every (N+1)-th burst, repeatedly within one transfer, with the base advancing each time.
- R8: Writes to the shadow registers (`shd_addr_we`, `shd_base_we`) during a transfer do not change `cur_addr` or the active base. The next `xfer_start` uses the written values.
- R9: `xfer_start` takes priority: `word_done` and `burst_done` are ignored in the same cycle. A shadow write in the same cycle as `xfer_start` does not reach the active set on that edge; the previous shadow value is copied.
- R10: All address arithmetic wraps modulo 2^32. Negative steps are applied as two's complement.
- R11: With none of `xfer_start`, `word_done` and `burst_done` high, `cur_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shd_addr_we | input | 1 | Write strobe for the shadow start address |
| shd_addr_wdata | input | 32 | Data for the shadow start address |
| shd_base_we | input | 1 | Write strobe for the shadow wrap base |
| shd_base_wdata | input | 32 | Data for the shadow wrap base |
| xfer_start | input | 1 | Start of transfer: copy shadows to the active set |
| word_done | input | 1 | One word has moved |
| burst_done | input | 1 | One burst has completed |
| word_step | input | 16 | Signed per-word address step |
| burst_step | input | 16 | Signed per-burst address step (non-wrap bursts) |
| wrap_size | input | 16 | Number of bursts between wraps, minus one |
| wrap_step | input | 16 | Signed step added to the base on each wrap |
| cur_addr | output | 32 | Active address |

## Verification
Every result of this block is registered once, so the effect of a strobe or a shadow write sampled at a rising edge is visible on `cur_addr` right after that same edge. There is no further latency. The bench changes inputs on the falling edge, holds each strobe for exactly one rising edge, and compares `cur_addr` one nanosecond after that edge. Effects that only show later, such as a copied base or a reloaded counter, are checked at the later burst that makes them visible: a wrap shows the base and the counter through the address it loads.

// File: rtl/dma_ag_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the DMA address generator.
// Assumes: nothing; holds only the burst-level action encoding.
package dma_ag_pkg;

    // What the burst-level logic does to the active address on this edge.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,   // no burst completed
        ACT_STEP = 2'd1,   // add the per-burst step
        ACT_WRAP = 2'd2    // advance base and reload address from it
    } burst_act_e;

endpackage

// File: rtl/dma_ag_shadow.sv
`timescale 1ns/1ps
// Module: dma_ag_shadow
// Holds the software-written start address and wrap base.
// Assumes: write strobes are single-cycle or level; the last write wins.
module dma_ag_shadow #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [ADDR_W-1:0] shd_addr,
    output logic [ADDR_W-1:0] shd_base
);

    // Capture software writes to the shadow start address.
    always_ff @(posedge clk) begin
        if (!rst_n)       shd_addr <= '0;
        else if (addr_we) shd_addr <= addr_wdata;
    end

    // Capture software writes to the shadow wrap base.
    always_ff @(posedge clk) begin
        if (!rst_n)       shd_base <= '0;
        else if (base_we) shd_base <= base_wdata;
    end

    // R8: shadows change only when written.
    assert_shadow_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_we |=> $stable(shd_addr));
    assert_shadow_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we |=> $stable(shd_base));

endmodule

// File: rtl/dma_ag_wrap_ctr.sv
`timescale 1ns/1ps
// Module: dma_ag_wrap_ctr
// Counts bursts down from the wrap size and decides, per burst,
// whether the burst-level update is a step or a wrap.
// Assumes: xfer_start has priority over burst_done in the same cycle.
module dma_ag_wrap_ctr
    import dma_ag_pkg::*;
#(
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              burst_done,
    input  logic [WRAP_W-1:0] wrap_size,
    output burst_act_e        act
);

    logic [WRAP_W-1:0] cnt_q;
    logic              at_zero;

    assign at_zero = (cnt_q == '0);

    // Classify the current burst edge as none, step or wrap.
    always_comb begin
        act = ACT_NONE;
        if (burst_done && !xfer_start) act = at_zero ? ACT_WRAP : ACT_STEP;
    end

    // Load on transfer start, reload on wrap, count down on other bursts.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (xfer_start)       cnt_q <= wrap_size;
        else if (act == ACT_WRAP)  cnt_q <= wrap_size;
        else if (act == ACT_STEP)  cnt_q <= cnt_q - 1'b1;
    end

    // R6: transfer start loads the counter from the wrap size.
    assert_cnt_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> cnt_q == $past(wrap_size));
    // R4: a non-wrapping burst counts down by one.
    assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !xfer_start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R7: a wrap reloads the counter.
    assert_cnt_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !xfer_start && cnt_q == '0) |=> cnt_q == $past(wrap_size));
    // R11: no burst and no start leaves the counter alone.
    assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_done && !xfer_start) |=> $stable(cnt_q));

endmodule

// File: rtl/dma_ag_base.sv
`timescale 1ns/1ps
// Module: dma_ag_base
// Active wrap base pointer: loaded from the shadow at transfer start,
// advanced by the signed wrap step on each wrap.
// Assumes: act already reflects xfer_start priority.
module dma_ag_base
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] shd_base,
    input  burst_act_e        act,
    input  logic [STEP_W-1:0] wrap_step,
    output logic [ADDR_W-1:0] wrap_base
);

    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] step_ext;

    // Sign-extend the wrap step to address width.
    assign step_ext  = {{EXT_W{wrap_step[STEP_W-1]}}, wrap_step};
    // Base value a wrap on this edge would produce (modulo 2^ADDR_W).
    assign wrap_base = base_q + step_ext;

    // Load from the shadow or advance on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)               base_q <= '0;
        else if (xfer_start)      base_q <= shd_base;
        else if (act == ACT_WRAP) base_q <= wrap_base;
    end

    // R2: transfer start copies the shadow base.
    assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> base_q == $past(shd_base));
    // R8: the base only moves on start or wrap, never on shadow writes.
    assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_start && act != ACT_WRAP) |=> $stable(base_q));

endmodule

// File: rtl/dma_ag_addr.sv
`timescale 1ns/1ps
// Module: dma_ag_addr
// Active address register. Applies the per-word step, then the
// burst-level step or wrap reload, in one registered update.
// Assumes: act already reflects xfer_start priority; wrap_base is the
// advanced base for this edge.
module dma_ag_addr
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] shd_addr,
    input  logic              word_done,
    input  logic [STEP_W-1:0] word_step,
    input  burst_act_e        act,
    input  logic [STEP_W-1:0] burst_step,
    input  logic [ADDR_W-1:0] wrap_base,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] word_ext;
    logic [ADDR_W-1:0] burst_ext;
    logic [ADDR_W-1:0] after_word;
    logic [ADDR_W-1:0] addr_next;

    // Sign-extend both steps to address width.
    assign word_ext  = {{EXT_W{word_step[STEP_W-1]}}, word_step};
    assign burst_ext = {{EXT_W{burst_step[STEP_W-1]}}, burst_step};

    // Word step first, so the burst-level change sees the stepped address.
    assign after_word = word_done ? (cur_addr + word_ext) : cur_addr;

    // Pick the next active address.
    always_comb begin
        unique case (act)
            ACT_STEP: addr_next = after_word + burst_ext;
            ACT_WRAP: addr_next = wrap_base;
            default:  addr_next = after_word;
        endcase
    end

    // Register the active address.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_addr <= '0;
        else if (xfer_start) cur_addr <= shd_addr;
        else                 cur_addr <= addr_next;
    end

    // R2: transfer start shows the shadow start address.
    assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> cur_addr == $past(shd_addr));
    // R6: a wrap loads the advanced base.
    assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_WRAP) |=> cur_addr == $past(wrap_base));
    // R11: no strobe, no change.
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_start && !word_done && act == ACT_NONE) |=> $stable(cur_addr));

endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
// Module: dma_addr_gen (top)
// Address generator for one side of a DMA channel: shadow/active
// start and base pointers, signed word and burst steps, burst-counted
// wrapping. Assumes strobes come from a sequencer, one per event.
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shd_addr_we,
    input  logic [ADDR_W-1:0] shd_addr_wdata,
    input  logic              shd_base_we,
    input  logic [ADDR_W-1:0] shd_base_wdata,
    input  logic              xfer_start,
    input  logic              word_done,
    input  logic              burst_done,
    input  logic [STEP_W-1:0] word_step,
    input  logic [STEP_W-1:0] burst_step,
    input  logic [WRAP_W-1:0] wrap_size,
    input  logic [STEP_W-1:0] wrap_step,
    output logic [ADDR_W-1:0] cur_addr
);

    import dma_ag_pkg::*;

    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] shd_addr;
    logic [ADDR_W-1:0] shd_base;
    logic [ADDR_W-1:0] wrap_base;
    burst_act_e        act;

    dma_ag_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (shd_addr_we),
        .addr_wdata (shd_addr_wdata),
        .base_we    (shd_base_we),
        .base_wdata (shd_base_wdata),
        .shd_addr   (shd_addr),
        .shd_base   (shd_base)
    );

    dma_ag_wrap_ctr #(.WRAP_W(WRAP_W)) u_wrap_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .burst_done (burst_done),
        .wrap_size  (wrap_size),
        .act        (act)
    );

    dma_ag_base #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .shd_base   (shd_base),
        .act        (act),
        .wrap_step  (wrap_step),
        .wrap_base  (wrap_base)
    );

    dma_ag_addr #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .shd_addr   (shd_addr),
        .word_done  (word_done),
        .word_step  (word_step),
        .act        (act),
        .burst_step (burst_step),
        .wrap_base  (wrap_base),
        .cur_addr   (cur_addr)
    );

    // R3 / R10: a lone word strobe moves the address by the signed step, modulo 2^ADDR_W.
    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !burst_done && !xfer_start) |=>
        cur_addr == $past(cur_addr) + {{EXT_W{$past(word_step[STEP_W-1])}}, $past(word_step)});
    // R9: with start high the strobes have no effect; the shadow value arrives.
    assert_start_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> cur_addr == $past(shd_addr));

endmodule

// File: tb/dma_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shd_addr_we = 1'b0;
    logic [31:0] shd_addr_wdata = '0;
    logic        shd_base_we = 1'b0;
    logic [31:0] shd_base_wdata = '0;
    logic        xfer_start = 1'b0;
    logic        word_done = 1'b0;
    logic        burst_done = 1'b0;
    logic [15:0] word_step = '0;
    logic [15:0] burst_step = '0;
    logic [15:0] wrap_size = '0;
    logic [15:0] wrap_step = '0;
    logic [31:0] cur_addr;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_addr_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .shd_addr_we    (shd_addr_we),
        .shd_addr_wdata (shd_addr_wdata),
        .shd_base_we    (shd_base_we),
        .shd_base_wdata (shd_base_wdata),
        .xfer_start     (xfer_start),
        .word_done      (word_done),
        .burst_done     (burst_done),
        .word_step      (word_step),
        .burst_step     (burst_step),
        .wrap_size      (wrap_size),
        .wrap_step      (wrap_step),
        .cur_addr       (cur_addr)
    );

    // One vector: strobes, steps, expected address after the edge.
    typedef struct packed {
        logic        st;
        logic        wd;
        logic        bd;
        logic [15:0] ws;
        logic [15:0] bs;
        logic [15:0] wrs;
        logic [31:0] ex;
    } vec_t;

    // Shadow start 0x1000, base 0x2000, wrap_size 1 (wrap on every 2nd burst).
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 16'h0002, 16'h0010, 16'h0100, 32'h0000_1000}, // R2 start
        '{1'b0, 1'b1, 1'b0, 16'h0002, 16'h0010, 16'h0100, 32'h0000_1002}, // R3
        '{1'b0, 1'b1, 1'b0, 16'h0002, 16'h0010, 16'h0100, 32'h0000_1004}, // R3
        '{1'b0, 1'b1, 1'b1, 16'h0002, 16'h0010, 16'h0100, 32'h0000_1016}, // R5 / R4
        '{1'b0, 1'b1, 1'b0, 16'h0002, 16'h0010, 16'h0100, 32'h0000_1018}, // R3
        '{1'b0, 1'b1, 1'b1, 16'h0002, 16'h0010, 16'h0100, 32'h0000_2100}, // R6 wrap
        '{1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0010, 16'h0100, 32'h0000_20FF}, // R10 negative
        '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h0010, 16'h0100, 32'h0000_210F}, // R4
        '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h0010, 16'h0100, 32'h0000_2200}, // R7 2nd wrap
        '{1'b0, 1'b0, 1'b0, 16'h0005, 16'h0010, 16'h0100, 32'h0000_2200}, // R11 idle
        '{1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFE0, 16'h0100, 32'h0000_21E0}, // R4 negative
        '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h0010, 16'hFF00, 32'h0000_2100}  // R7 negative wrap
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: cur_addr=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive inputs for exactly one rising edge, then sample just after it.
    task automatic step_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        xfer_start = 1'b0; word_done = 1'b0; burst_done = 1'b0;
        shd_addr_we = 1'b0; shd_base_we = 1'b0;
    endtask

    task automatic write_shadows(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        shd_addr_we = 1'b1; shd_addr_wdata = a;
        shd_base_we = 1'b1; shd_base_wdata = b;
        step_edge();
        clear_strobes();
    endtask

    task automatic pulse(input logic st, input logic wd, input logic bd);
        @(negedge clk);
        xfer_start = st; word_done = wd; burst_done = bd;
        step_edge();
        clear_strobes();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: cur_addr=%h expected=finish", cur_addr);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", cur_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        pulse(1'b1, 1'b0, 1'b0);
        check("R1 start after reset uses cleared shadow", cur_addr, 32'h0);

        // Table-driven main function.
        write_shadows(32'h0000_1000, 32'h0000_2000);
        wrap_size = 16'd1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            xfer_start = VEC[i].st; word_done = VEC[i].wd; burst_done = VEC[i].bd;
            word_step = VEC[i].ws; burst_step = VEC[i].bs; wrap_step = VEC[i].wrs;
            step_edge();
            clear_strobes();
            check($sformatf("vector %0d (R2-R7,R10,R11)", i), cur_addr, VEC[i].ex);
        end

        // R8: shadow writes mid-transfer do not touch the active set.
        write_shadows(32'h0000_3000, 32'h0000_4000);
        wrap_size = 16'd0; wrap_step = 16'h0010; word_step = 16'h0004; burst_step = 16'h0008;
        pulse(1'b1, 1'b0, 1'b0);
        check("R2 start", cur_addr, 32'h0000_3000);
        write_shadows(32'h0000_5000, 32'h0000_6000);
        check("R8 addr unaffected by shadow write", cur_addr, 32'h0000_3000);
        pulse(1'b0, 1'b0, 1'b1);
        check("R8 wrap uses old active base", cur_addr, 32'h0000_4010);
        pulse(1'b1, 1'b0, 1'b0);
        check("R8 next start takes new shadow", cur_addr, 32'h0000_5000);
        pulse(1'b0, 1'b0, 1'b1);
        check("R2 new base copied at start", cur_addr, 32'h0000_6010);

        // R9: start wins over strobes and over a same-cycle shadow write.
        @(negedge clk);
        xfer_start = 1'b1; word_done = 1'b1; burst_done = 1'b1;
        shd_addr_we = 1'b1; shd_addr_wdata = 32'h0000_7000;
        step_edge();
        clear_strobes();
        check("R9 start priority, old shadow copied", cur_addr, 32'h0000_5000);
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 written shadow seen at next start", cur_addr, 32'h0000_7000);

        // R10: modulo 2^32 arithmetic in both directions.
        write_shadows(32'hFFFF_FFFE, 32'h0);
        wrap_size = 16'd5;
        pulse(1'b1, 1'b0, 1'b0);
        word_step = 16'h0004;
        pulse(1'b0, 1'b1, 1'b0);
        check("R10 overflow wraps", cur_addr, 32'h0000_0002);
        word_step = 16'hFFFC;
        pulse(1'b0, 1'b1, 1'b0);
        check("R10 underflow wraps", cur_addr, 32'hFFFF_FFFE);

        // R1: reset mid-run clears the address.
        @(negedge clk);
        rst_n = 1'b0;
        step_edge();
        check("R1 reset mid-run", cur_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule